// File: doc/BRIEF.md
# Clock Select Register File

This block is a bank of 32-bit configuration words that hold the divider codes and source-select codes steering a chip's clock generators. Software reaches it over a plain register bus: a valid strobe, a write flag, a byte address and 32-bit write and read data. Each word is a set of packed fields. Every field has its own write-enable bit, so one bus write can change one field and leave its neighbours as they were, with no read-modify-write.

Two of the words are double-buffered. Writes to them land in a pending copy, and the clock generators keep seeing the old settings. Software then writes a change-request word. That word reads as busy for a fixed number of cycles. When the busy phase ends, both pending copies move to the live outputs on the same clock edge and the request word reads idle again. The live value of each configured word is driven out to the clock-generation logic as a 32-bit image.

Top module: `clksel_regfile`

## Requirements
- R1: Register number n (counting from 1) sits at byte address (n-1)*4. The word index is bus_addr[ADDR_W-1:2] and the two low address bits are ignored. The implemented registers are 1 (0x00), 8 (0x1C), 9 (0x20), 10 (0x24) and the change-request register 11 (0x28).
- R2: Field layout, written as start bit/width. Register 1: 0/3, 3/5, 8/5, 13/5, 18/4, 22/7, 29/3. Register 8: 3/3. Register 9: 0/7, 7/5, 12/4, 16/4, 20/4. Register 10: 0/3, 3/4, 7/3. Within each field the top bit is the write-enable bit and the bits below it hold the code.
- R3: A write changes a field's code only when the write sets that field's enable bit. Every field whose enable bit is clear keeps its stored code.
- R4: A read returns the live codes. Enable bits and bits that belong to no field read as zero.
- R5: A write to register 1 or 8 appears on sel_word1 or sel_word8 in the cycle after the write edge.
- R6: A write to register 9 or 10 updates only a pending copy. The readback and sel_word9/sel_word10 keep their old values until an apply completes.
- R7: Writing register 11 with bit 0 set while it is idle starts an apply. From the next cycle, register 11 reads 1 for exactly APPLY_CYCLES cycles (8 by default) and then reads 0. On the edge where it clears, both pending copies become live together.
- R8: A write to register 11 with bit 0 clear has no effect. A write to register 11 while an apply is running neither restarts nor extends it.
- R9: Pending writes to registers 9 and 10 made while an apply is running are included in that apply.
- R10: Undefined addresses read zero, and writes to them change no register and no output.
- R11: Reset (synchronous, active high) loads register 1 = 0x2000_0013, register 8 = 0x0000_0000, register 9 = 0x0073_338F and register 10 = 0x0000_0099 into both live and pending copies. Register 11 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, including the field enable bits |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sel_word1 | output | 32 | Live image of register 1 |
| sel_word8 | output | 32 | Live image of register 8 |
| sel_word9 | output | 32 | Live image of register 9 |
| sel_word10 | output | 32 | Live image of register 10 |

## Verification
The hardest case to reach from the ports is a collision with an apply that is already running. This means a second change request arriving mid-apply, or a pending write that must slip into the apply in progress. A directed sequence issues a request, then a write to register 10, then a second request on back-to-back cycles. It then polls register 11 to confirm that the busy count is not stretched and that the late write went live. A long random phase mixes requests, partial-enable writes and stray addresses, and compares against a behavioural model on every cycle.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int REQ_INDEX = 10;   // register 11

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        APPLY_IDLE = 1'b0,
        APPLY_RUN  = 1'b1
    } apply_state_e;

    typedef struct packed {
        logic [7:0] index;       // word index = register number - 1
        logic       staged;      // held pending until an apply
        word_t      field_mask;  // bits belonging to some field
        word_t      en_mask;     // top bit of each field
        word_t      reset_val;   // default codes
    } word_desc_t;

    function automatic word_desc_t word_desc(input int i);
        word_desc_t d;
        case (i)
            0:       d = '{index: 8'd0, staged: 1'b0, field_mask: 32'hFFFF_FFFF,
                           en_mask: 32'h9022_1084, reset_val: 32'h2000_0013};
            1:       d = '{index: 8'd7, staged: 1'b0, field_mask: 32'h0000_0038,
                           en_mask: 32'h0000_0020, reset_val: 32'h0000_0000};
            2:       d = '{index: 8'd8, staged: 1'b1, field_mask: 32'h00FF_FFFF,
                           en_mask: 32'h0088_8840, reset_val: 32'h0073_338F};
            default: d = '{index: 8'd9, staged: 1'b1, field_mask: 32'h0000_03FF,
                           en_mask: 32'h0000_0244, reset_val: 32'h0000_0099};
        endcase
        return d;
    endfunction

    // Position of the enable bit that owns data bit b: lowest set bit >= b.
    function automatic int en_pos(input word_t m, input int b);
        int p;
        p = WORD_W - 1;
        for (int k = WORD_W - 1; k >= b; k--) begin
            if (m[k]) p = k;
        end
        return p;
    endfunction

endpackage

// File: rtl/clksel_word.sv
module clksel_word
    import clksel_pkg::*;
#(
    parameter word_t FIELD_MASK = '0,
    parameter word_t EN_MASK    = '0,
    parameter word_t RESET_VAL  = '0,
    parameter bit    STAGED     = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  word_t wdata,
    input  logic  apply,
    output word_t live
);

    localparam word_t DATA_MASK = FIELD_MASK & ~EN_MASK;
    localparam word_t INIT_VAL  = RESET_VAL & DATA_MASK;

    word_t base_q;   // copy that bus writes act upon
    word_t base_d;

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (DATA_MASK[b]) begin : g_data
            localparam int EP = en_pos(EN_MASK, b);
            assign base_d[b] = (wr && wdata[EP]) ? wdata[b] : base_q[b];
        end else begin : g_zero
            assign base_d[b] = 1'b0;
        end
    end

    if (STAGED) begin : g_staged
        word_t pend_q;
        word_t live_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= INIT_VAL;
                live_q <= INIT_VAL;
            end else begin
                pend_q <= base_d;
                if (apply) live_q <= pend_q;
            end
        end

        assign base_q = pend_q;
        assign live   = live_q;

        assert_live_hold_R6: assert property (@(posedge clk) disable iff (rst)
            !apply |=> $stable(live_q));
        assert_pend_keep_R3: assert property (@(posedge clk) disable iff (rst)
            !(wr && |(wdata & EN_MASK)) |=> $stable(pend_q));
    end else begin : g_direct
        word_t live_q;
        logic  unused_apply;

        always_ff @(posedge clk) begin
            if (rst) live_q <= INIT_VAL;
            else     live_q <= base_d;
        end

        assign base_q       = live_q;
        assign live         = live_q;
        assign unused_apply = apply;

        assert_live_keep_R3: assert property (@(posedge clk) disable iff (rst)
            !(wr && |(wdata & EN_MASK)) |=> $stable(live_q));
    end

endmodule

// File: rtl/clksel_apply_ctrl.sv
module clksel_apply_ctrl
    import clksel_pkg::*;
#(
    parameter int APPLY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic busy,
    output logic apply
);

    localparam int             CW   = $clog2(APPLY_CYCLES + 1);
    localparam logic [CW-1:0]  LAST = CW'(APPLY_CYCLES - 1);

    apply_state_e  st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= APPLY_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                APPLY_IDLE: begin
                    if (req) begin
                        st_q  <= APPLY_RUN;
                        cnt_q <= LAST;
                    end
                end
                default: begin
                    if (cnt_q == '0) st_q  <= APPLY_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign busy  = (st_q == APPLY_RUN);
    assign apply = busy && (cnt_q == '0);

    assert_req_starts_R7: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> (busy && cnt_q == LAST));
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> !(busy && cnt_q == LAST));
    assert_apply_ends_R7: assert property (@(posedge clk) disable iff (rst)
        apply |=> !busy);

endmodule

// File: rtl/clksel_regfile.sv
module clksel_regfile
    import clksel_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int APPLY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       sel_word1,
    output logic [31:0]       sel_word8,
    output logic [31:0]       sel_word9,
    output logic [31:0]       sel_word10
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lsb;
    logic             wr_any;
    logic             req_hit;
    logic             busy;
    logic             apply;
    logic             word_wr [NUM_WORDS];
    word_t            live    [NUM_WORDS];

    assign idx        = bus_addr[ADDR_W-1:2];
    assign unused_lsb = bus_addr[1:0];
    assign wr_any     = bus_valid && bus_write;
    assign req_hit    = wr_any && (int'(idx) == REQ_INDEX) && bus_wdata[0];

    clksel_apply_ctrl #(.APPLY_CYCLES(APPLY_CYCLES)) u_apply (
        .clk   (clk),
        .rst   (rst),
        .req   (req_hit),
        .busy  (busy),
        .apply (apply)
    );

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam word_desc_t DESC = word_desc(i);

        assign word_wr[i] = wr_any && (int'(idx) == int'(DESC.index));

        clksel_word #(
            .FIELD_MASK (DESC.field_mask),
            .EN_MASK    (DESC.en_mask),
            .RESET_VAL  (DESC.reset_val),
            .STAGED     (DESC.staged)
        ) u_word (
            .clk   (clk),
            .rst   (rst),
            .wr    (word_wr[i]),
            .wdata (bus_wdata),
            .apply (apply),
            .live  (live[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (int'(idx) == int'(word_desc(i).index)) bus_rdata = live[i];
        end
        if (int'(idx) == REQ_INDEX) bus_rdata = {31'b0, busy};
    end

    assign sel_word1  = live[0];
    assign sel_word8  = live[1];
    assign sel_word9  = live[2];
    assign sel_word10 = live[3];

    assert_idle_after_reset_R11: assert property (@(posedge clk)
        $fell(rst) |-> !busy);

endmodule

// File: tb/tb_clksel_regfile.sv
module tb_clksel_regfile;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata, sel_word1, sel_word8, sel_word9, sel_word10;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    clksel_regfile #(.ADDR_W(AW), .APPLY_CYCLES(8)) dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sel_word1(sel_word1), .sel_word8(sel_word8),
        .sel_word9(sel_word9), .sel_word10(sel_word10)
    );

    // ---------------- behavioural reference model ----------------
    int          nf [4]     = '{7, 1, 5, 3};
    int          fsh[4][7]  = '{'{0, 3, 8, 13, 18, 22, 29}, '{3, 0, 0, 0, 0, 0, 0},
                               '{0, 7, 12, 16, 20, 0, 0}, '{0, 3, 7, 0, 0, 0, 0}};
    int          fwd[4][7]  = '{'{3, 5, 5, 5, 4, 7, 3}, '{3, 0, 0, 0, 0, 0, 0},
                               '{7, 5, 4, 4, 4, 0, 0}, '{3, 4, 3, 0, 0, 0, 0}};
    int          reg_no[4]  = '{1, 8, 9, 10};
    logic [31:0] dflt[4]    = '{32'h2000_0013, 32'h0, 32'h0073_338F, 32'h0000_0099};
    logic [31:0] m_live[4];
    logic [31:0] m_pend[4];
    bit          m_busy = 1'b0;
    int          m_left = 0;

    function automatic logic [31:0] field_write(int r, logic [31:0] old, logic [31:0] wd);
        logic [31:0] res = old;
        for (int f = 0; f < nf[r]; f++) begin
            int en = fsh[r][f] + fwd[r][f] - 1;
            if (wd[en]) begin
                for (int k = fsh[r][f]; k < en; k++) res[k] = wd[k];
            end
        end
        return res;
    endfunction

    function automatic int word_of(logic [AW-1:0] a);
        int n = int'(a >> 2) + 1;
        for (int r = 0; r < 4; r++) if (reg_no[r] == n) return r;
        return -1;
    endfunction

    function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
        int r = word_of(a);
        if (int'(a >> 2) + 1 == 11) return {31'b0, m_busy};
        if (r >= 0) return m_live[r];
        return 32'h0;
    endfunction

    function automatic string rd_tag(logic [AW-1:0] a);
        int r = word_of(a);
        if (int'(a >> 2) + 1 == 11) return "R7";
        if (r < 0) return "R10";
        return (r < 2) ? "R4" : "R6";
    endfunction

    function automatic logic [31:0] port_of(int r);
        case (r)
            0: return sel_word1;
            1: return sel_word8;
            2: return sel_word9;
            default: return sel_word10;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  r;
        bit  was_busy;
        if (rst) begin
            for (int k = 0; k < 4; k++) begin
                m_live[k] = dflt[k];
                m_pend[k] = dflt[k];
            end
            m_busy = 1'b0;
            m_left = 0;
        end else begin
            was_busy = m_busy;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_live[2] = m_pend[2];
                    m_live[3] = m_pend[3];
                    m_busy    = 1'b0;
                end
            end
            if (bus_valid && bus_write) begin
                r = word_of(bus_addr);
                if (r >= 2)      m_pend[r] = field_write(r, m_pend[r], bus_wdata);
                else if (r >= 0) m_live[r] = field_write(r, m_live[r], bus_wdata);
                else if (int'(bus_addr >> 2) + 1 == 11 && bus_wdata[0] && !was_busy) begin
                    m_busy = 1'b1;
                    m_left = 8;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // every-cycle comparison, before drivers move (they wait 2 ns past negedge)
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk(rd_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
            for (int r = 0; r < 4; r++) chk((r < 2) ? "R5" : "R6", port_of(r), m_live[r]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk); #2;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); #2;
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic count_busy(int window, output int ones);
        ones = 0;
        for (int k = 0; k < window; k++) begin
            @(negedge clk); #3;
            if (bus_rdata[0]) ones++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] s1, s8, s9, s10;
        int ones;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cmp_on = 1'b1;

        // R11: reset defaults
        rd(8'h00, d); chk("R11", d, 32'h2000_0013);
        rd(8'h20, d); chk("R11", d, 32'h0073_338F);
        rd(8'h24, d); chk("R11", d, 32'h0000_0099);
        rd(8'h28, d); chk("R11", d, 32'h0);

        // R2/R5: code 5 into register 1 field at bit 3 (enable bit 7)
        wr(8'h00, 32'h0000_00A8);
        rd(8'h00, d); chk("R2", d, 32'h2000_002B);
        chk("R5", sel_word1, 32'h2000_002B);
        // R4: the enable bit just written reads back as zero
        chk("R4", {31'b0, d[7]}, 32'h0);

        // R3: all data bits set, every enable bit clear -> nothing changes
        wr(8'h00, 32'h6FDD_EF7B);
        rd(8'h00, d); chk("R3", d, 32'h2000_002B);

        // R6: register 9 written with all ones stays pending
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d); chk("R6", d, 32'h0073_338F);
        chk("R6", sel_word9, 32'h0073_338F);

        // R7: request, busy for exactly 8 cycles, then live
        wr(8'h28, 32'h1);
        count_busy(20, ones); chk("R7", ones, 8);
        rd(8'h20, d); chk("R7", d, 32'h0077_77BF);
        chk("R7", sel_word9, 32'h0077_77BF);

        // R8: bit 0 clear does not start an apply
        wr(8'h28, 32'hFFFF_FFFE);
        rd(8'h28, d); chk("R8", d, 32'h0);

        // R8/R9: request, pending write, second request on back-to-back cycles
        wr(8'h28, 32'h1);
        wr(8'h24, 32'h0000_0380);
        wr(8'h28, 32'h1);
        count_busy(20, ones); chk("R8", ones, 6);   // 2 of 8 busy cycles already gone
        rd(8'h24, d); chk("R9", d, 32'h0000_0199);
        chk("R9", sel_word10, 32'h0000_0199);

        // R10: undefined addresses
        s1 = sel_word1; s8 = sel_word8; s9 = sel_word9; s10 = sel_word10;
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h3C, d); chk("R10", d, 32'h0);
        rd(8'h04, d); chk("R10", d, 32'h0);
        chk("R10", sel_word1, s1);  chk("R10", sel_word8, s8);
        chk("R10", sel_word9, s9);  chk("R10", sel_word10, s10);

        // R1: low address bits ignored; register 8 at 0x1C
        rd(8'h22, d); chk("R1", d, 32'h0077_77BF);
        wr(8'h1F, 32'h0000_0038);
        rd(8'h1C, d); chk("R1", d, 32'h0000_0018);

        // mixed random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] pick [10] = '{8'h00, 8'h1C, 8'h20, 8'h24, 8'h28,
                                          8'h28, 8'h04, 8'h3C, 8'h21, 8'hFC};
            @(negedge clk); #2;
            bus_addr  = ($urandom % 8 == 0) ? AW'($urandom) : pick[$urandom % 10];
            bus_valid = ($urandom % 2) == 0;
            bus_write = ($urandom % 3) != 0;
            bus_wdata = $urandom;
        end
        @(negedge clk); #2;
        bus_valid = 1'b0; bus_write = 1'b0;
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule